// File: doc/BRIEF.md
# Machine-Mode CSR Read-Modify-Write Unit

This unit carries out the three atomic control-and-status register instructions of a machine-mode core: swap (write the source, return the old value), set bits and clear bits. The source is either a register value supplied by the register file or a 5-bit immediate field that is zero-extended to the full data width. The unit holds the machine CSRs itself, returns the value read before any change for the destination register, and decides whether a write takes place.

The pipeline presents one request per cycle with a valid strobe. All answers (old value, illegal flag, write-taken flag) are combinational in that same cycle; the register update lands on the next rising clock edge. Requests to addresses the unit does not hold, requests from too low a privilege level, and writes to read-only addresses raise the illegal flag and leave every register as it was.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (op code 2'b01) replaces the addressed CSR with the source; the new value reads back on the next access.
- R2: Swap writes on every legal request, even when the source, register index or immediate is zero (write-taken flag is 1).
- R3: Set (op 2'b10) stores old OR source; clear (op 2'b11) stores old AND NOT source.
- R4: Set and clear write only when the 5-bit source field is nonzero; in register form that field is the register index, so a zero index suppresses the write whatever the register value, and a nonzero index writes even when the value is zero.
- R5: With use_imm set, the source is the 5-bit field zero-extended to the data width; the register value is ignored.
- R6: On a legal valid request the destination output carries the CSR value held before the request; on illegal or idle cycles it is zero.
- R7: Implemented addresses are 0x300 status, 0x302 exception delegation, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 trap value and 0xF14 hart ID; any other address raises illegal and writes nothing.
- R8: Address bits [9:8] give the lowest privilege allowed (privilege input: 2'b00 user, 2'b01 supervisor, 2'b11 machine); a lower privilege raises illegal and writes nothing.
- R9: An address with bits [11:10] equal to 2'b11 is read-only: a request that would write it is illegal, while a non-writing set/clear is legal; the hart ID reads as zero.
- R10: State changes only on a clock edge with valid high and no illegal flag; after reset every CSR reads zero.
- R11: Op code 2'b00 is reserved and raises illegal with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 01 swap, 10 set, 11 clear, 00 reserved |
| use_imm_i | input | 1 | Source is the zero-extended 5-bit field |
| src_idx_i | input | 5 | Register index or immediate field |
| src_val_i | input | 64 | Register value for register form |
| csr_addr_i | input | 12 | CSR number |
| priv_i | input | 2 | Current privilege level |
| rd_data_o | output | 64 | Old CSR value for the destination |
| illegal_o | output | 1 | Illegal-instruction indication |
| wr_en_o | output | 1 | A CSR write takes place at the next edge |

## Verification
The bench builds the unit with the default 64-bit data width and 5-bit immediate field, so clear masks and swap data reach bit 63 while immediates can only touch bits 4:0, which makes any sign extension or width slip of the immediate visible. Random requests draw from the held addresses plus an unheld neighbour, a supervisor-level address and the read-only hart ID, under all three privilege levels, so the illegal, read-only and zero-field suppression paths each recur many times against a shadow copy of the register set.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  parameter int CSR_XLEN  = 64;
  parameter int ADDR_W    = 12;
  parameter int FIELD_W   = 5;
  parameter int NUM_SLOTS = 7;
  localparam int SLOT_W   = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    OP_RSVD = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  localparam logic [ADDR_W-1:0] SLOT_ADDR [NUM_SLOTS] = '{
    12'h300, 12'h302, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343
  };
  localparam logic [ADDR_W-1:0] HART_ADDR = 12'hF14;

  function automatic logic [CSR_XLEN-1:0] rmw_apply(
    input csr_op_e op, input logic [CSR_XLEN-1:0] old_v, input logic [CSR_XLEN-1:0] src);
    case (op)
      OP_SWAP: return src;
      OP_SET:  return old_v | src;
      OP_CLR:  return old_v & ~src;
      default: return old_v;
    endcase
  endfunction

  function automatic logic wants_write(input csr_op_e op, input logic [FIELD_W-1:0] field);
    return (op == OP_SWAP) || ((op != OP_RSVD) && (field != '0));
  endfunction
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_rmw_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_SLOTS-1:0] hit_o,
  output logic [SLOT_W-1:0]   slot_o,
  output logic                is_hart_o,
  output logic                impl_o,
  output logic                read_only_o,
  output logic [1:0]          min_priv_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign hit_o[g] = (addr_i == SLOT_ADDR[g]);
  end

  always_comb begin
    slot_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit_o[i]) slot_o = SLOT_W'(i);
    end
  end

  assign is_hart_o   = (addr_i == HART_ADDR);
  assign impl_o      = (|hit_o) | is_hart_o;
  assign read_only_o = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
  assign min_priv_o  = addr_i[ADDR_W-3:ADDR_W-4];
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_rmw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] we_i,
  input  logic [CSR_XLEN-1:0]  wdata_i,
  input  logic [SLOT_W-1:0]    rslot_i,
  output logic [CSR_XLEN-1:0]  rdata_o
);
  logic [CSR_XLEN-1:0] regs [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[g] <= '0;
      else if (we_i[g]) regs[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rslot_i == SLOT_W'(i)) rdata_o = regs[i];
    end
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [1:0]          op_i,
  input  logic                use_imm_i,
  input  logic [FIELD_W-1:0]  src_idx_i,
  input  logic [CSR_XLEN-1:0] src_val_i,
  input  logic [ADDR_W-1:0]   csr_addr_i,
  input  logic [1:0]          priv_i,
  output logic [CSR_XLEN-1:0] rd_data_o,
  output logic                illegal_o,
  output logic                wr_en_o
);
  logic [NUM_SLOTS-1:0] hit;
  logic [SLOT_W-1:0]    slot;
  logic                 is_hart, impl, read_only;
  logic [1:0]           min_priv;
  logic [CSR_XLEN-1:0]  stored, old_val, src, new_val;
  logic                 intent, priv_low, ro_violation;
  csr_op_e              op;

  assign op = csr_op_e'(op_i);

  csr_addr_decode u_dec (
    .addr_i(csr_addr_i), .hit_o(hit), .slot_o(slot), .is_hart_o(is_hart),
    .impl_o(impl), .read_only_o(read_only), .min_priv_o(min_priv)
  );

  assign src          = use_imm_i ? {{(CSR_XLEN-FIELD_W){1'b0}}, src_idx_i} : src_val_i;
  assign intent       = wants_write(op, src_idx_i);
  assign priv_low     = (priv_i < min_priv);
  assign ro_violation = read_only & intent;
  assign illegal_o    = valid_i & ((op == OP_RSVD) | ~impl | priv_low | ro_violation);
  assign wr_en_o      = valid_i & ~illegal_o & intent;

  assign old_val   = (impl & ~is_hart) ? stored : '0;
  assign rd_data_o = (valid_i & ~illegal_o) ? old_val : '0;
  assign new_val   = rmw_apply(op, old_val, src);

  csr_store u_store (
    .clk(clk), .rst_n(rst_n), .we_i(hit & {NUM_SLOTS{wr_en_o}}),
    .wdata_i(new_val), .rslot_i(slot), .rdata_o(stored)
  );
endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk
  import csr_rmw_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                valid_i,
  input logic [1:0]          op_i,
  input logic                use_imm_i,
  input logic [FIELD_W-1:0]  src_idx_i,
  input logic [ADDR_W-1:0]   csr_addr_i,
  input logic [1:0]          priv_i,
  input logic [CSR_XLEN-1:0] rd_data_o,
  input logic                illegal_o,
  input logic                wr_en_o
);
  assert_swap_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b01 && !illegal_o) |-> wr_en_o);

  assert_zero_field_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i[1] && src_idx_i == '0) |-> !wr_en_o);

  assert_illegal_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wr_en_o);

  assert_low_priv_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && priv_i < csr_addr_i[9:8]) |-> illegal_o);

  assert_ro_swap_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && csr_addr_i[11:10] == 2'b11 && op_i == 2'b01) |-> illegal_o);

  assert_reserved_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b00) |-> illegal_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!wr_en_o && !illegal_o && rd_data_o == '0));

  assert_no_write_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(valid_i) && !$past(wr_en_o) && !$past(illegal_o) && !illegal_o
     && csr_addr_i == $past(csr_addr_i)) |-> rd_data_o == $past(rd_data_o));
endmodule

bind csr_rmw_unit csr_rmw_unit_chk u_chk (.*);

// File: tb/csr_rmw_unit_bench.sv
`timescale 1ns/1ps
module csr_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        use_imm_i = 1'b0;
  logic [4:0]  src_idx_i = '0;
  logic [63:0] src_val_i = '0;
  logic [11:0] csr_addr_i = '0;
  logic [1:0]  priv_i = 2'b11;
  logic [63:0] rd_data_o;
  logic        illegal_o, wr_en_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] shadow [7];
  logic [11:0] addrs [7] = '{12'h300, 12'h302, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343};

  always #10 clk = ~clk;

  csr_rmw_unit u_csr_rmw_unit (.*);

  function automatic int find_slot(input logic [11:0] a);
    for (int i = 0; i < 7; i++) if (addrs[i] == a) return i;
    return -1;
  endfunction

  task automatic access(input bit v, input logic [1:0] op, input bit imm, input logic [4:0] idx,
                        input logic [63:0] val, input logic [11:0] a, input logic [1:0] pr,
                        input string tag);
    int s;
    bit known, ill, wr;
    logic [63:0] old, srcv, nv, exp_rd;
    s = find_slot(a);
    known = (s >= 0) || (a == 12'hF14);
    old = (s >= 0) ? shadow[s] : 64'd0;
    srcv = imm ? 64'(idx) : val;
    wr = (op == 2'b01) || (op != 2'b00 && idx != 5'd0);
    ill = v && (op == 2'b00 || !known || pr < a[9:8] || (a[11:10] == 2'b11 && wr));
    wr = v && !ill && wr;
    exp_rd = (v && !ill) ? old : 64'd0;
    case (op)
      2'b01: nv = srcv;
      2'b10: nv = old | srcv;
      default: nv = old ^ (old & srcv);
    endcase
    @(negedge clk);
    valid_i = v; op_i = op; use_imm_i = imm; src_idx_i = idx; src_val_i = val;
    csr_addr_i = a; priv_i = pr;
    #2;
    checks++;
    if (rd_data_o !== exp_rd || illegal_o !== ill || wr_en_o !== wr) begin
      fails++;
      $display("FAIL %s addr=%h op=%b: rd=%h ill=%b wr=%b expected rd=%h ill=%b wr=%b",
               tag, a, op, rd_data_o, illegal_o, wr_en_o, exp_rd, ill, wr);
    end
    @(posedge clk);
    if (wr && s >= 0) shadow[s] = nv;
  endtask

  task automatic peek(input logic [11:0] a, input string tag);
    access(1'b1, 2'b10, 1'b1, 5'd0, 64'd0, a, 2'b11, tag);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: reset state
    for (int i = 0; i < 7; i++) peek(addrs[i], "R10 reset");
    // R1 / R6 swap and old value
    access(1, 2'b01, 0, 5'd7, 64'hDEAD_BEEF_0123_4567, 12'h340, 2'b11, "R1 swap");
    peek(12'h340, "R6 old value");
    // R2 swap with zero immediate still writes
    access(1, 2'b01, 1, 5'd0, 64'hFFFF, 12'h340, 2'b11, "R2 zero swap");
    peek(12'h340, "R2 readback");
    // R3 set / clear with full width
    access(1, 2'b01, 0, 5'd3, 64'hF0F0_0000_0000_00FF, 12'h341, 2'b11, "R1 load");
    access(1, 2'b10, 0, 5'd3, 64'h8000_0000_0000_0100, 12'h341, 2'b11, "R3 set");
    access(1, 2'b11, 0, 5'd3, 64'hF000_0000_0000_000F, 12'h341, 2'b11, "R3 clear");
    peek(12'h341, "R3 readback");
    // R4 zero index suppresses; nonzero index with zero value writes
    access(1, 2'b10, 0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h341, 2'b11, "R4 zero idx");
    access(1, 2'b11, 0, 5'd9, 64'd0, 12'h341, 2'b11, "R4 zero value");
    peek(12'h341, "R4 readback");
    // R5 immediate zero extension ignores register value
    access(1, 2'b10, 1, 5'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 12'h342, 2'b11, "R5 imm set");
    access(1, 2'b11, 1, 5'h10, 64'h0, 12'h342, 2'b11, "R5 imm clear");
    peek(12'h342, "R5 readback");
    // R7 unimplemented
    access(1, 2'b01, 0, 5'd1, 64'h1234, 12'h301, 2'b11, "R7 unimpl");
    // R8 privilege
    access(1, 2'b01, 0, 5'd1, 64'h55, 12'h300, 2'b01, "R8 low priv");
    peek(12'h300, "R8 untouched");
    // R9 read-only
    access(1, 2'b01, 0, 5'd0, 64'h1, 12'hF14, 2'b11, "R9 ro swap");
    access(1, 2'b10, 1, 5'd0, 64'h0, 12'hF14, 2'b11, "R9 ro read");
    // R11 reserved op
    access(1, 2'b00, 0, 5'd4, 64'h77, 12'h305, 2'b11, "R11 reserved");
    peek(12'h305, "R11 untouched");
    // R10 idle cycle does nothing
    access(0, 2'b01, 0, 5'd2, 64'hABCD, 12'h302, 2'b11, "R10 idle");
    peek(12'h302, "R10 untouched");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [1:0] pr;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 7) ? addrs[pick] : (pick == 7) ? 12'hF14 : (pick == 8) ? 12'h301 : 12'h100;
      pr = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1)) : 2'b11;
      access(($urandom_range(0, 9) != 0), 2'($urandom), 1'($urandom),
             ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom),
             {$urandom, $urandom}, a, pr, "R3 random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule